// File: doc/BRIEF.md
# Wiegand 26-bit frame receiver

This block takes in one 26-bit Wiegand frame from a card reader. The reader uses two idle-high lines. A short low pulse on the zero line sends a 0, and a short low pulse on the one line sends a 1. The first bit and the last bit of the frame are parity bits, and the block drops both. The 24 payload bits between them are collected into a word. The first payload bit received becomes the most significant bit of that word.

When 25 pulses have been counted, the word is complete and the valid flag goes high. From then on the block ignores both lines, so the trailing parity bit is never taken in. The word stays held until the consumer pulses the acknowledge input.

A free-running prescaler makes a timeout tick. If two ticks pass with no pulse while a frame is only partly received, the partial frame is thrown away. The next burst then starts cleanly from its leading bit. Checking parity and turning the word into text are left to the consumer.

Top module: `wiegand_rx`

## Requirements
- R1: While reset is held, and on the clock edge after it, `data` is 0 and `valid` is 0.
- R2: The first pulse of a frame is counted but not stored. Each of the next 24 pulses shifts its bit into `data[0]` and moves the earlier bits up by one. The first payload bit ends up in `data[23]`.
- R3: A low pulse on `zero_n` gives bit value 0, and a low pulse on `one_n` gives bit value 1. Both lines pass through two synchronizer flops. A falling edge is detected one cycle after the synchronized line goes low. So the new `data` value appears on the third rising clock edge after the line is driven low. One pulse always gives exactly one bit.
- R4: `valid` rises once 25 pulses have been counted. While `valid` is high, further pulses on either line change neither `data` nor `valid`. This includes the trailing parity bit.
- R5: A high `ack` clears `data` and `valid` on the next edge and re-enables capture for a new frame.
- R6: Every pulse restarts the timeout. If two timeout ticks come in a row with no pulse while between 1 and 24 pulses have been counted, `data` and the pulse count are cleared. A gap that spans at most one tick keeps the frame intact.
- R7: Timeout ticks never clear a completed frame that is waiting for `ack`.
- R8: If both synchronized lines fall in the same cycle, the event is ignored and the pulse count does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_n | input | 1 | Asynchronous line, pulsed low for a 0 bit |
| one_n | input | 1 | Asynchronous line, pulsed low for a 1 bit |
| ack | input | 1 | Consumer strobe that releases the held frame |
| data | output | DATA_W (24) | Collected payload, first payload bit in the MSB |
| valid | output | 1 | High while a complete frame is held |

## Verification
A line driven low updates `data` on the third rising edge after it. The bench drives that line at a falling edge. It checks that `data` has not changed after the second rising edge and has changed after the third.

`ack` takes effect on the first rising edge, so it is checked one cycle later.

Timeout behaviour depends on the tick phase. The bench therefore runs the prescaler at 64 cycles. It keeps gaps between pulses at 12 cycles, well below one tick. Abandoned frames are left idle for more than three tick periods before they are checked, so the two-tick clear is certain to have happened.

// File: rtl/wiegand_rx.sv
module wiegand_rx #(
  parameter int DATA_W   = 24,
  parameter int TICK_DIV = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_n,
  input  logic              one_n,
  input  logic              ack,
  output logic [DATA_W-1:0] data,
  output logic              valid
);
  localparam int CW = $clog2(DATA_W + 2);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] DONE = CW'(DATA_W + 1);
  localparam logic [PW-1:0] PMAX = PW'(TICK_DIV - 1);

  logic [2:0]        z_sh, o_sh;
  logic [CW-1:0]     cnt;
  logic [PW-1:0]     presc;
  logic              tick, stale;
  logic              fall_z, fall_o, pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z_sh <= '1;
      o_sh <= '1;
    end else begin
      z_sh <= {z_sh[1:0], zero_n};
      o_sh <= {o_sh[1:0], one_n};
    end
  end

  assign fall_z = z_sh[2] & ~z_sh[1];
  assign fall_o = o_sh[2] & ~o_sh[1];
  assign pulse  = (fall_z ^ fall_o) & (cnt != DONE);
  assign valid  = (cnt == DONE);
  assign tick   = (presc == PMAX);

  always_ff @(posedge clk) begin
    if (!rst_n || tick) presc <= '0;
    else                presc <= presc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ack) begin
      cnt   <= '0;
      data  <= '0;
      stale <= 1'b0;
    end else if (pulse) begin
      cnt   <= cnt + 1'b1;
      stale <= 1'b0;
      if (cnt != '0) data <= {data[DATA_W-2:0], fall_o};
    end else if (tick && cnt != '0) begin
      if (!stale) stale <= 1'b1;
      else if (cnt != DONE) begin
        cnt  <= '0;
        data <= '0;
      end
    end
  end
endmodule

module wiegand_rx_chk #(
  parameter int DATA_W = 24,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [DATA_W-1:0] data,
  input logic              valid,
  input logic [CW-1:0]     cnt,
  input logic              tick,
  input logic              stale,
  input logic              pulse
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (data == '0 && !valid));

  p_shift_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !valid) |=> (data == '0 || data == $past(data) ||
                          data[DATA_W-1:1] == $past(data[DATA_W-2:0])));

  p_hold_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> (valid && $stable(data)));

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!valid && data == '0));

  p_abort_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stale && !pulse && !ack && cnt != '0 && !valid) |=> (cnt == '0 && data == '0));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DATA_W + 1));
endmodule

bind wiegand_rx wiegand_rx_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .data(data), .valid(valid),
  .cnt(cnt), .tick(tick), .stale(stale), .pulse(pulse)
);

// File: tb/wiegand_rx_tb.sv
module wiegand_rx_tb;
  localparam int DW = 24;
  logic clk = 0, rst_n = 0, zero_n = 1, one_n = 1, ack = 0;
  logic [DW-1:0] data;
  logic valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiegand_rx #(.DATA_W(DW), .TICK_DIV(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .zero_n(zero_n), .one_n(one_n),
    .ack(ack), .data(data), .valid(valid));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    if (b) one_n = 0; else zero_n = 0;
    idle(4);
    one_n = 1; zero_n = 1;
    idle(8);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic lead, input logic trail);
    send_bit(lead);
    for (int i = DW - 1; i >= 0; i--) send_bit(d[i]);
    send_bit(trail);
    idle(6);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic t_reset();
    idle(3);
    chk(data == 0 && !valid, "R1 reset state", {7'd0, valid, data}, 32'd0);
    rst_n = 1;
    idle(2);
    chk(data == 0 && !valid, "R1 after reset release", {7'd0, valid, data}, 32'd0);
  endtask

  task automatic t_frame(input logic [DW-1:0] d, input logic lead, input logic trail, input string tag);
    send_frame(d, lead, trail);
    chk(valid, {tag, " R4 valid"}, 32'(valid), 32'd1);
    chk(data == d, {tag, " R2 payload"}, 32'(data), 32'(d));
    do_ack();
    chk(data == 0 && !valid, {tag, " R5 ack clears"}, {7'd0, valid, data}, 32'd0);
  endtask

  task automatic t_lockout();
    send_frame(24'h5A3C81, 1'b0, 1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    idle(6);
    chk(valid && data == 24'h5A3C81, "R4 extra pulses ignored", 32'(data), 32'h5A3C81);
    idle(300);
    chk(valid && data == 24'h5A3C81, "R7 ticks keep done frame", 32'(data), 32'h5A3C81);
    do_ack();
    chk(!valid, "R5 valid drops on ack", 32'(valid), 32'd0);
    t_frame(24'h13579B, 1'b1, 1'b0, "recapture");
  endtask

  task automatic t_timing();
    send_bit(1'b0);
    @(negedge clk); one_n = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(data == 0, "R3 not yet after 2 edges", 32'(data), 32'd0);
    @(negedge clk);
    chk(data == 1, "R3 bit 1 after 3 edges", 32'(data), 32'd1);
    idle(3); one_n = 1; idle(8);
    chk(data == 1, "R3 one pulse one bit", 32'(data), 32'd1);
    send_bit(1'b0);
    chk(data == 2, "R3 zero line gives 0", 32'(data), 32'd2);
    idle(260);
    chk(data == 0 && !valid, "R6 partial frame cleared", {7'd0, valid, data}, 32'd0);
    t_frame(24'hC0FFEE, 1'b0, 1'b0, "after abort R6");
  endtask

  task automatic t_both_low();
    send_bit(1'b1);
    @(negedge clk); zero_n = 0; one_n = 0;
    idle(4); zero_n = 1; one_n = 1; idle(8);
    for (int i = DW - 1; i >= 0; i--) send_bit(i[0]);
    send_bit(1'b1);
    idle(6);
    chk(valid && data == 24'hAAAAAA, "R8 simultaneous fall ignored", 32'(data), 32'hAAAAAA);
    do_ack();
  endtask

  initial begin
    t_reset();
    t_frame(24'h800001, 1'b0, 1'b0, "edges");
    t_frame(24'hFFFFFF, 1'b1, 1'b1, "ones");
    t_frame(24'h000000, 1'b1, 1'b1, "zeros");
    t_lockout();
    t_timing();
    t_both_low();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule